// File: doc/BRIEF.md
# Dual-Issue Packet Issue Checker

This block is the issue-stage control of an in-order pipeline that issues statically scheduled two-instruction packets. Each cycle fetch may present one packet: lane 0 carries an ALU or branch operation and lane 1 carries a load or store, each already decoded into a valid bit, an operation class, a destination register and a set of source registers. The block screens each lane for a legal class and checks two hazards. The first is a lane-1 memory operation that reads the lane-0 ALU result of the same packet, which cannot be forwarded. The second is a packet that reads the destination of a load issued in the cycle just before. It then decides whether both lanes issue, only lane 0 issues with lane 1 held back, or nothing issues and a bubble enters both lanes.

The decision, the per-lane issue valids, the fetch stall and the bubble flag are all registered. While the block raises its fetch stall it keeps its own copy of whatever part of the packet is still waiting and ignores the fetch inputs. On the next cycle it runs the waiting part through the same checks again. Every other dependency between consecutive packets is assumed to be covered by forwarding and costs no cycle.

Top module: `dual_issue_checker`

## Requirements
- R1: Class codes are ALU=0, BRANCH=1, LOAD=2, STORE=3. Lane 0 accepts only ALU or BRANCH and lane 1 accepts only LOAD or STORE. A valid slot with any other class is treated as a nop and sets `illegal_packet`, which stays set until reset.
- R2: A slot with its valid bit clear issues nothing and creates no dependency, whatever its register fields hold.
- R3: With no hazard, the edge that accepts a packet sets `issue_valid` to {lane 1 valid, lane 0 valid} (bit 0 is lane 0), with `fetch_stall` and `bubble` low.
- R4: If lane 0 is an ALU operation with destination not 0 and either lane-1 source equals that destination, the packet is split. The first cycle shows `issue_valid`=01 with `fetch_stall`=1, and the next cycle shows `issue_valid`=10 with `fetch_stall`=0.
- R5: A branch in lane 0 writes no register, so it never causes a split.
- R6: If the previous cycle issued a load in lane 1 with destination not 0, and any valid lane of the current packet reads that destination, the block shows `issue_valid`=00, `bubble`=1 and `fetch_stall`=1. The whole packet is kept and issues on the next cycle with no load-use check.
- R7: A packet that was held back by a load-use bubble is checked again for the split hazard when it is re-issued, and it splits if that check calls for it.
- R8: Reads of an ALU result from the previous packet, reads after a store, and reads of a load destination two or more cycles after the load issued cause no stall.
- R9: Register 0 is never a dependency, whether it appears as a destination or as a source.
- R10: While `fetch_stall` is 1, the fetch inputs are ignored for the next edge.
- R11: Synchronous active-low reset clears `issue_valid`, `fetch_stall`, `bubble`, `illegal_packet`, the held packet and the load tracker. The first packet after reset is not checked against a load from before reset.
- R12: A cycle with no packet presented gives `issue_valid`=00 and `bubble`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_valid | input | 1 | Fetch presents a packet this cycle |
| l0_valid | input | 1 | Lane-0 slot holds an instruction |
| l0_class | input | 2 | Lane-0 operation class |
| l0_dst | input | REG_W | Lane-0 destination register |
| l0_src | input | NSRC*REG_W | Lane-0 source registers, source 0 in the low bits |
| l1_valid | input | 1 | Lane-1 slot holds an instruction |
| l1_class | input | 2 | Lane-1 operation class |
| l1_dst | input | REG_W | Lane-1 destination register |
| l1_src | input | NSRC*REG_W | Lane-1 source registers, source 0 in the low bits |
| issue_valid | output | 2 | Per-lane issue valid, bit 0 is lane 0 |
| fetch_stall | output | 1 | Holds fetch; the block is issuing from its held copy |
| bubble | output | 1 | A load-use bubble entered both lanes |
| illegal_packet | output | 1 | Sticky: a slot had a class illegal for its lane |

## Verification
The assertions check on every cycle that a split is always followed by a lone lane-1 issue with fetch released, and that a bubble never lasts two cycles in a row. They also check that the illegal flag never clears without reset, that a stall cycle cannot change that flag (the inputs are ignored), and that reset clears every output. Only the bench scenarios can show that the hazards are detected for the right register matches: the register-0 exemption, branch destinations, stores, slots with valid clear, and a load two cycles back. The same holds for the bubble-then-split order of a packet with both hazards, and for the absence of a stale load check after reset.

// File: rtl/dic_pkg.sv
`timescale 1ns/1ps
// Package: shared definitions for the dual-issue packet issue checker.
// Assumes a two-lane packet, lane 0 for ALU/branch and lane 1 for memory.
package dic_pkg;

    // Operation class carried by each pre-decoded slot.
    typedef enum logic [1:0] {
        CL_ALU    = 2'd0,
        CL_BRANCH = 2'd1,
        CL_LOAD   = 2'd2,
        CL_STORE  = 2'd3
    } op_class_e;

    localparam int unsigned LANES   = 2;
    localparam int unsigned LANE_OP = 0;
    localparam int unsigned LANE_MEM = 1;

endpackage

// File: rtl/dic_slot_screen.sv
`timescale 1ns/1ps
// Module: dic_slot_screen
// Screens one lane of a packet. It decides whether the slot is a legal,
// effective instruction for its lane position and whether it writes a
// non-zero register. Assumes LANE 0 takes ALU/branch and any other lane
// takes load/store. Purely combinational.
module dic_slot_screen
    import dic_pkg::*;
#(
    parameter int unsigned REG_W = 5,
    parameter int unsigned LANE  = 0
) (
    input  logic             slot_valid,
    input  logic [1:0]       slot_class,
    input  logic [REG_W-1:0] slot_dst,
    output logic             eff_valid,
    output logic             bad_class,
    output logic             writes_reg
);

    logic class_ok;
    logic class_writes;

    // Lane position picks the set of classes it may carry.
    generate
        if (LANE == LANE_OP) begin : g_op_lane
            assign class_ok = (slot_class == CL_ALU) || (slot_class == CL_BRANCH);
        end else begin : g_mem_lane
            assign class_ok = (slot_class == CL_LOAD) || (slot_class == CL_STORE);
        end
    endgenerate

    // Only ALU results and load data land in a register.
    assign class_writes = (slot_class == CL_ALU) || (slot_class == CL_LOAD);

    // Legality and write decision for this slot.
    always_comb begin
        eff_valid  = slot_valid && class_ok;
        bad_class  = slot_valid && !class_ok;
        writes_reg = slot_valid && class_ok && class_writes && (slot_dst != '0);
    end

endmodule

// File: rtl/dic_read_match.sv
`timescale 1ns/1ps
// Module: dic_read_match
// Reports whether any of a slot's source registers equals a producer tag.
// A zero tag never matches (register 0 is constant). Assumes the sources
// are packed with source 0 in the low bits. Purely combinational.
module dic_read_match #(
    parameter int unsigned REG_W = 5,
    parameter int unsigned NSRC  = 2
) (
    input  logic                  reader_en,
    input  logic [REG_W-1:0]      tag,
    input  logic [NSRC*REG_W-1:0] srcs,
    output logic                  hit
);

    logic [NSRC-1:0] src_eq;

    // One comparator per source register.
    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            assign src_eq[i] = (srcs[i*REG_W +: REG_W] == tag);
        end
    endgenerate

    // Combine comparators, drop register 0 and disabled readers.
    assign hit = reader_en && (tag != '0) && (|src_eq);

endmodule

// File: rtl/dic_hazard.sv
`timescale 1ns/1ps
// Module: dic_hazard
// Finds the two hazards of the packet now at issue: a load-use against the
// load issued last cycle, and an in-packet read of the lane-0 result by
// lane 1. Both flags are raw; the caller applies priority. Assumes slot
// validity and write flags come from dic_slot_screen.
module dic_hazard #(
    parameter int unsigned REG_W = 5,
    parameter int unsigned NSRC  = 2
) (
    input  logic                  op_eff,
    input  logic                  op_writes,
    input  logic [REG_W-1:0]      op_dst,
    input  logic [NSRC*REG_W-1:0] op_src,
    input  logic                  mem_eff,
    input  logic [NSRC*REG_W-1:0] mem_src,
    input  logic                  ld_pending,
    input  logic [REG_W-1:0]      ld_dst,
    output logic                  load_use,
    output logic                  intra_dep
);

    logic op_reads_ld;
    logic mem_reads_ld;
    logic mem_reads_op;

    dic_read_match #(.REG_W(REG_W), .NSRC(NSRC)) u_op_vs_ld (
        .reader_en (op_eff),
        .tag       (ld_dst),
        .srcs      (op_src),
        .hit       (op_reads_ld)
    );

    dic_read_match #(.REG_W(REG_W), .NSRC(NSRC)) u_mem_vs_ld (
        .reader_en (mem_eff),
        .tag       (ld_dst),
        .srcs      (mem_src),
        .hit       (mem_reads_ld)
    );

    dic_read_match #(.REG_W(REG_W), .NSRC(NSRC)) u_mem_vs_op (
        .reader_en (mem_eff && op_writes),
        .tag       (op_dst),
        .srcs      (mem_src),
        .hit       (mem_reads_op)
    );

    // Hazard flags from the three comparisons.
    always_comb begin
        load_use  = ld_pending && (op_reads_ld || mem_reads_ld);
        intra_dep = mem_reads_op;
    end

endmodule

// File: rtl/dual_issue_checker.sv
`timescale 1ns/1ps
// Module: dual_issue_checker
// Issue-stage control for two-lane statically scheduled packets. It picks
// the packet at issue (its own held copy while stalling, else the fetch
// inputs), screens each lane, resolves load-use (bubble) before the in-packet
// split, and registers the issue valids, fetch stall and bubble flag.
// Assumes fetch holds off while fetch_stall is high; inputs are ignored then.
module dual_issue_checker
    import dic_pkg::*;
#(
    parameter int unsigned REG_W = 5,
    parameter int unsigned NSRC  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pkt_valid,
    input  logic                  l0_valid,
    input  logic [1:0]            l0_class,
    input  logic [REG_W-1:0]      l0_dst,
    input  logic [NSRC*REG_W-1:0] l0_src,
    input  logic                  l1_valid,
    input  logic [1:0]            l1_class,
    input  logic [REG_W-1:0]      l1_dst,
    input  logic [NSRC*REG_W-1:0] l1_src,
    output logic [LANES-1:0]      issue_valid,
    output logic                  fetch_stall,
    output logic                  bubble,
    output logic                  illegal_packet
);

    localparam int unsigned SRC_W = NSRC * REG_W;

    // Packet currently at issue.
    logic             cur_v   [LANES];
    logic [1:0]       cur_c   [LANES];
    logic [REG_W-1:0] cur_d   [LANES];
    logic [SRC_W-1:0] cur_s   [LANES];

    // Held copy while stalling.
    logic             held_v  [LANES];
    logic [1:0]       held_c  [LANES];
    logic [REG_W-1:0] held_d  [LANES];
    logic [SRC_W-1:0] held_s  [LANES];

    // Screen results.
    logic [LANES-1:0] lane_eff;
    logic [LANES-1:0] lane_bad;
    logic [LANES-1:0] lane_wr;

    // Load issued in lane 1 on the previous cycle.
    logic             ld_pend_q;
    logic [REG_W-1:0] ld_dst_q;

    logic hz_load_use;
    logic hz_intra;

    // Select the packet at issue: held copy, fresh fetch, or empty.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            cur_v[l] = 1'b0;
            cur_c[l] = held_c[l];
            cur_d[l] = held_d[l];
            cur_s[l] = held_s[l];
        end
        if (fetch_stall) begin
            for (int l = 0; l < LANES; l++) begin
                cur_v[l] = held_v[l];
            end
        end else if (pkt_valid) begin
            cur_v[LANE_OP]  = l0_valid;
            cur_c[LANE_OP]  = l0_class;
            cur_d[LANE_OP]  = l0_dst;
            cur_s[LANE_OP]  = l0_src;
            cur_v[LANE_MEM] = l1_valid;
            cur_c[LANE_MEM] = l1_class;
            cur_d[LANE_MEM] = l1_dst;
            cur_s[LANE_MEM] = l1_src;
        end
    end

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            dic_slot_screen #(.REG_W(REG_W), .LANE(g)) u_screen (
                .slot_valid (cur_v[g]),
                .slot_class (cur_c[g]),
                .slot_dst   (cur_d[g]),
                .eff_valid  (lane_eff[g]),
                .bad_class  (lane_bad[g]),
                .writes_reg (lane_wr[g])
            );
        end
    endgenerate

    dic_hazard #(.REG_W(REG_W), .NSRC(NSRC)) u_hazard (
        .op_eff     (lane_eff[LANE_OP]),
        .op_writes  (lane_wr[LANE_OP] && (cur_c[LANE_OP] == CL_ALU)),
        .op_dst     (cur_d[LANE_OP]),
        .op_src     (cur_s[LANE_OP]),
        .mem_eff    (lane_eff[LANE_MEM]),
        .mem_src    (cur_s[LANE_MEM]),
        .ld_pending (ld_pend_q),
        .ld_dst     (ld_dst_q),
        .load_use   (hz_load_use),
        .intra_dep  (hz_intra)
    );

    // Register the issue decision, held packet and load tracker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_valid    <= '0;
            fetch_stall    <= 1'b0;
            bubble         <= 1'b0;
            illegal_packet <= 1'b0;
            ld_pend_q      <= 1'b0;
            ld_dst_q       <= '0;
            for (int l = 0; l < LANES; l++) begin
                held_v[l] <= 1'b0;
                held_c[l] <= '0;
                held_d[l] <= '0;
                held_s[l] <= '0;
            end
        end else begin
            illegal_packet <= illegal_packet || (|lane_bad);
            if (hz_load_use) begin
                issue_valid <= '0;
                fetch_stall <= 1'b1;
                bubble      <= 1'b1;
                ld_pend_q   <= 1'b0;
                for (int l = 0; l < LANES; l++) begin
                    held_v[l] <= lane_eff[l];
                    held_c[l] <= cur_c[l];
                    held_d[l] <= cur_d[l];
                    held_s[l] <= cur_s[l];
                end
            end else if (hz_intra) begin
                issue_valid           <= '0;
                issue_valid[LANE_OP]  <= 1'b1;
                fetch_stall           <= 1'b1;
                bubble                <= 1'b0;
                ld_pend_q             <= 1'b0;
                held_v[LANE_OP]       <= 1'b0;
                held_v[LANE_MEM]      <= 1'b1;
                held_c[LANE_MEM]      <= cur_c[LANE_MEM];
                held_d[LANE_MEM]      <= cur_d[LANE_MEM];
                held_s[LANE_MEM]      <= cur_s[LANE_MEM];
            end else begin
                issue_valid <= lane_eff;
                fetch_stall <= 1'b0;
                bubble      <= 1'b0;
                ld_pend_q   <= lane_wr[LANE_MEM] && (cur_c[LANE_MEM] == CL_LOAD);
                ld_dst_q    <= cur_d[LANE_MEM];
                for (int l = 0; l < LANES; l++) begin
                    held_v[l] <= 1'b0;
                end
            end
        end
    end

    // R11: reset leaves every output cleared.
    assert_reset_clears_R11: assert property (@(posedge clk)
        !rst_n |=> (issue_valid == '0 && !fetch_stall && !bubble && !illegal_packet))
        else $error("reset did not clear outputs");

    // R1: the illegal flag only clears through reset.
    assert_illegal_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_packet |=> illegal_packet)
        else $error("illegal_packet dropped");

    // R4: a split is followed by a lone lane-1 issue with fetch released.
    assert_split_tail_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_stall && !bubble) |=> (issue_valid == 2'b10 && !fetch_stall))
        else $error("split tail wrong");

    // R6: a re-issued packet is never bubbled a second time.
    assert_bubble_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |=> !bubble)
        else $error("bubble repeated");

    // R10: inputs seen during a stall cannot raise the illegal flag.
    assert_stall_ignores_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall |=> (illegal_packet == $past(illegal_packet)))
        else $error("input used during stall");

endmodule

// File: tb/dual_issue_checker_bench.sv
`timescale 1ns/1ps
module dual_issue_checker_bench;

    localparam int RW = 5;
    localparam int NS = 2;
    localparam int A = 0, B = 1, L = 2, S = 3;

    typedef struct packed {
        logic       pv;
        logic       v0;
        logic [1:0] c0;
        logic [4:0] d0, a0, b0;
        logic       v1;
        logic [1:0] c1;
        logic [4:0] d1, a1, b1;
        logic [1:0] eiv;
        logic       efs, ebub, eill;
    } vec_t;

    function automatic vec_t mk(input int pv, v0, c0, d0, a0, b0,
                                input int v1, c1, d1, a1, b1,
                                input int iv, fs, bb, il);
        vec_t v;
        v.pv = pv[0]; v.v0 = v0[0]; v.c0 = c0[1:0];
        v.d0 = d0[4:0]; v.a0 = a0[4:0]; v.b0 = b0[4:0];
        v.v1 = v1[0]; v.c1 = c1[1:0];
        v.d1 = d1[4:0]; v.a1 = a1[4:0]; v.b1 = b1[4:0];
        v.eiv = iv[1:0]; v.efs = fs[0]; v.ebub = bb[0]; v.eill = il[0];
        return v;
    endfunction

    localparam int NV = 23;
    localparam vec_t TBL [NV] = '{
        mk(0, 0,A,0,0,0,   0,A,0,0,0,   0,0,0,0), // R12 empty cycle
        mk(1, 1,A,3,1,2,   1,L,4,5,0,   3,0,0,0), // R3 both issue
        mk(1, 1,A,8,6,7,   1,S,0,9,10,  3,0,0,0), // R3 unrelated
        mk(1, 1,A,5,1,2,   1,L,6,5,0,   1,1,0,0), // R4 split head
        mk(1, 1,L,0,0,0,   0,A,0,0,0,   2,0,0,0), // R4 tail, R10 junk ignored
        mk(1, 1,A,7,6,1,   0,A,0,0,0,   0,1,1,0), // R6 lane0 reads load
        mk(0, 0,A,0,0,0,   0,A,0,0,0,   1,0,0,0), // R6 reissue
        mk(1, 1,A,10,11,12,1,L,9,1,0,   3,0,0,0), // R3
        mk(1, 1,A,12,13,14,1,S,0,2,9,   0,1,1,0), // R6 lane1 reads load
        mk(1, 0,A,20,21,22,0,S,0,23,24, 3,0,0,0), // R6 reissue, R10 ignored
        mk(1, 0,A,0,0,0,   1,L,13,1,0,  2,0,0,0), // R2 lane0 nop
        mk(1, 1,A,14,13,0, 1,L,15,14,0, 0,1,1,0), // R7 bubble first
        mk(0, 0,A,0,0,0,   0,A,0,0,0,   1,1,0,0), // R7 then split
        mk(0, 0,A,0,0,0,   0,A,0,0,0,   2,0,0,0), // R7 tail
        mk(1, 1,A,0,3,4,   1,L,0,0,0,   3,0,0,0), // R9 dst 0 no split
        mk(1, 1,A,1,0,0,   1,S,0,0,0,   3,0,0,0), // R9 load to r0 no bubble
        mk(1, 1,B,5,1,2,   1,L,3,5,0,   3,0,0,0), // R5 branch dst
        mk(1, 0,A,0,3,3,   0,L,0,3,3,   0,0,0,0), // R2 invalid readers
        mk(1, 1,A,2,3,3,   0,A,0,0,0,   1,0,0,0), // R8 load two back
        mk(1, 1,L,4,1,1,   1,L,5,4,0,   2,0,0,1), // R1 bad lane0 class
        mk(1, 1,A,6,1,2,   1,A,0,6,0,   1,0,0,1), // R1 bad lane1 class
        mk(1, 1,A,7,6,6,   1,S,0,6,6,   3,0,0,1), // R8 ALU result forwarded
        mk(0, 0,A,0,0,0,   0,A,0,0,0,   0,0,0,1)  // R1 sticky
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          pkt_valid, l0_valid, l1_valid;
    logic [1:0]    l0_class, l1_class;
    logic [RW-1:0] l0_dst, l1_dst;
    logic [NS*RW-1:0] l0_src, l1_src;
    logic [1:0]    issue_valid;
    logic          fetch_stall, bubble, illegal_packet;

    int applied = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dual_issue_checker #(.REG_W(RW), .NSRC(NS)) u_dual_issue_checker (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid),
        .l0_valid(l0_valid), .l0_class(l0_class), .l0_dst(l0_dst), .l0_src(l0_src),
        .l1_valid(l1_valid), .l1_class(l1_class), .l1_dst(l1_dst), .l1_src(l1_src),
        .issue_valid(issue_valid), .fetch_stall(fetch_stall),
        .bubble(bubble), .illegal_packet(illegal_packet)
    );

    task automatic drive(input vec_t v, input logic rv);
        rst_n     = rv;
        pkt_valid = v.pv;
        l0_valid  = v.v0; l0_class = v.c0; l0_dst = v.d0; l0_src = {v.b0, v.a0};
        l1_valid  = v.v1; l1_class = v.c1; l1_dst = v.d1; l1_src = {v.b1, v.a1};
    endtask

    // Drive at a falling edge, let one rising edge pass, compare at the next falling edge.
    task automatic step(input vec_t v, input logic rv, input string req);
        drive(v, rv);
        @(posedge clk);
        @(negedge clk);
        applied++;
        if (issue_valid !== v.eiv || fetch_stall !== v.efs ||
            bubble !== v.ebub || illegal_packet !== v.eill) begin
            miscompares++;
            $display("FAIL %s: got iv=%b fs=%b bub=%b ill=%b, expected iv=%b fs=%b bub=%b ill=%b",
                     req, issue_valid, fetch_stall, bubble, illegal_packet,
                     v.eiv, v.efs, v.ebub, v.eill);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got running, expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    end

    initial begin
        drive(mk(0,0,0,0,0,0,0,0,0,0,0,0,0,0,0), 1'b0);
        @(negedge clk);
        // R11 reset state
        step(mk(1, 1,A,3,1,2, 1,L,4,5,0, 0,0,0,0), 1'b0, "R11 reset state");

        for (int i = 0; i < NV; i++) begin
            step(TBL[i], 1'b1, $sformatf("vector %0d (R1-table)", i));
        end

        // R11: reset clears sticky flag
        step(mk(1, 1,A,3,1,2, 1,L,4,5,0, 0,0,0,0), 1'b0, "R11 clears illegal");
        // R11: no stale load check after reset
        step(mk(1, 0,A,0,0,0, 1,L,7,1,0, 2,0,0,0), 1'b1, "R11 load before reset");
        step(mk(0, 0,A,0,0,0, 0,A,0,0,0, 0,0,0,0), 1'b0, "R11 reset cycle");
        step(mk(1, 1,A,1,7,7, 0,A,0,0,0, 1,0,0,0), 1'b1, "R11 no stale load-use");
        // R11: reset drops a held split tail
        step(mk(1, 1,A,5,1,2, 1,S,0,5,5, 1,1,0,0), 1'b1, "R4 split head");
        step(mk(0, 0,A,0,0,0, 0,A,0,0,0, 0,0,0,0), 1'b0, "R11 reset during stall");
        step(mk(0, 0,A,0,0,0, 0,A,0,0,0, 0,0,0,0), 1'b1, "R11 held tail cleared");
        // R9: source 0 against pending load to a real register
        step(mk(1, 0,A,0,0,0, 1,L,9,1,0, 2,0,0,0), 1'b1, "R9 load r9");
        step(mk(1, 1,A,2,0,0, 1,S,0,0,0, 3,0,0,0), 1'b1, "R9 r0 readers");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

endmodule